// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the divider settings of one of five integer-mode PLLs without any software stepping through the procedure. A requester presents a PLL index and the four divider values (reference divider, feedback multiplier, first and second post dividers) together with a one-cycle start pulse. The sequencer first checks that the request describes a legal operating point. It rejects a bad request at once, before any register is touched. For a good request it drives a register-bank port through a fixed procedure. It parks the PLL in slow mode and switches it to integer operation. It then writes the divider fields by read-modify-write, samples the lock flag at a programmable interval until it sets, and finally returns the PLL to normal mode.

The register bank holds one shared mode register and two control words per PLL. Control word 0 of PLL `n` sits at address `2n` and control word 1 at address `2n+1`. The mode register sits at address `MODE_ADDR`, which defaults to 15. Reads return data on the cycle after the read strobe. The sample interval and the number of unlocked samples allowed before giving up are parameters. They are counted in clock cycles and samples, so a 1 µs interval at 125 MHz is `POLL_CYCLES = 125`.

Top module: `pll_reprog_seq`

## Requirements
- R1: A request is rejected when the index is 5 or more, or when the reference divider or either post divider is zero. It is also rejected when the feedback multiplier lies outside 16..3200, or when the VCO rate (24 MHz × feedback multiplier / reference divider) lies outside 800..3200 MHz. An output rate (VCO / first post divider / second post divider) outside 16..3200 MHz also rejects it. A rejected request raises `done` and `err` together two cycles after the start pulse and issues no register write.
- R2: An accepted request that locks issues exactly five writes, in this order: mode register (slow), control word 1 (integer mode), control word 0 (dividers), control word 1 (dividers), mode register (normal).
- R3: The mode bit of PLL index 0, 1, 2, 3, 4 is bit 0, 1, 4, 8, 12 of the mode register. The first mode write clears that bit and the last sets it. Every other mode bit keeps the value it was read with.
- R4: The integer-mode write sets bit 12 of control word 1, leaves its other bits as read, and comes before either divider write.
- R5: The control word 0 write puts the feedback multiplier in bits 11:0 and the first post divider in bits 14:12, and keeps bit 15 as read.
- R6: The divider write to control word 1 puts the reference divider in bits 5:0 and the second post divider in bits 8:6, and keeps bits 9 and 11..15 as read.
- R7: After the divider writes, bit 10 of control word 1 is read as the lock flag. Successive unlocked samples are exactly `POLL_CYCLES + 2` cycles apart, and the normal-mode write is issued only after a sample that showed lock.
- R8: If `MAX_POLLS` samples in a row show no lock, the request ends with `done` and `err` together, no further write is issued, and the PLL's mode bit is left at 0.
- R9: Out of reset, `busy`, `done`, `err`, `reg_rd` and `reg_wr` are 0. `busy` is high from the cycle after an accepted start through the `done` cycle. `done` lasts one cycle, and `err` is high only together with `done`.
- R10: A start pulse that arrives while `busy` is high is ignored: it produces no second `done` and no access to another PLL.
- R11: `reg_rd` and `reg_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request strobe |
| req_idx | input | 3 | PLL index, 0..4 |
| req_ref | input | 6 | Reference divider |
| req_fb | input | 12 | Feedback multiplier |
| req_pd1 | input | 3 | First post divider |
| req_pd2 | input | 3 | Second post divider |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Failure flag, valid with done |
| reg_addr | output | 4 | Register-bank address |
| reg_rd | output | 1 | Read strobe, data one cycle later |
| reg_wr | output | 1 | Write strobe |
| reg_wdata | output | 16 | Write data |
| reg_rdata | input | 16 | Read data |

## Verification
A wrong step or state in the sequencer appears on the register port within one access. It shows as a write to the wrong address, a write out of order, or a field that does not carry the requested value or the preserved bits. The bench logs every write against the order and contents it expects. A miscount in the poll timer shows as a wrong spacing between two lock samples, or as a wrong number of samples before a timeout. A faulty range decision shows two cycles after start, as `err` that does not match an independent kHz calculation, together with a write count that is not zero or not five.

// File: rtl/pll_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, field positions, legal ranges and state types for
// the PLL reprogramming sequencer. Assumes a 16-bit register bank.
package pll_seq_pkg;
    localparam int DW       = 16;
    localparam int NUM_PLL  = 5;
    localparam int IDX_W    = 3;
    localparam int AW       = IDX_W + 1;
    localparam int REF_W    = 6;
    localparam int FB_W     = 12;
    localparam int PD_W     = 3;

    // Field positions inside the control words and lock/integer flags
    localparam int FB_LSB   = 0;
    localparam int PD1_LSB  = 12;
    localparam int REF_LSB  = 0;
    localparam int PD2_LSB  = 6;
    localparam int LOCK_BIT = 10;
    localparam int INT_BIT  = 12;

    // Legal operating ranges, rates in MHz
    localparam int REF_MHZ  = 24;
    localparam int FB_MIN   = 16;
    localparam int FB_MAX   = 3200;
    localparam int VCO_MIN  = 800;
    localparam int VCO_MAX  = 3200;
    localparam int OUT_MIN  = 16;
    localparam int OUT_MAX  = 3200;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CHECK, ST_RD, ST_CAP, ST_WR,
        ST_POLL, ST_PCAP, ST_GAP, ST_DONE, ST_FAIL
    } seq_state_t;

    typedef enum logic [2:0] {
        STEP_SLOW, STEP_INT, STEP_DIV0, STEP_DIV1, STEP_NORM
    } seq_step_t;

    // Bit position of each PLL's slow/normal flag in the shared mode register
    function automatic logic [3:0] mode_pos(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return 4'd0;
            3'd1:    return 4'd1;
            3'd2:    return 4'd4;
            3'd3:    return 4'd8;
            3'd4:    return 4'd12;
            default: return 4'd0;
        endcase
    endfunction
endpackage

// File: rtl/pll_range_check.sv
`timescale 1ns/1ps
// Module: pll_range_check
// Decides whether a latched request names a real PLL and a legal operating
// point. Rate limits are compared by cross-multiplication, so no divider is
// needed. Assumes inputs are stable while the sequencer sits in its check state.
module pll_range_check
    import pll_seq_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic [REF_W-1:0] refdiv,
    input  logic [FB_W-1:0]  fbdiv,
    input  logic [PD_W-1:0]  pd1,
    input  logic [PD_W-1:0]  pd2,
    output logic             ok
);
    logic [31:0] fb_rate;
    logic [31:0] ref_v;
    logic [31:0] prod;
    logic        idx_ok, nz_ok, fb_ok, vco_ok, out_ok;

    // Combinational range decision over index, multiplier, VCO and output
    always_comb begin
        fb_rate = 32'(REF_MHZ) * 32'(fbdiv);
        ref_v   = 32'(refdiv);
        prod    = ref_v * 32'(pd1) * 32'(pd2);
        idx_ok  = 32'(idx) < 32'(NUM_PLL);
        nz_ok   = (refdiv != '0) && (pd1 != '0) && (pd2 != '0);
        fb_ok   = (32'(fbdiv) >= 32'(FB_MIN)) && (32'(fbdiv) <= 32'(FB_MAX));
        vco_ok  = (fb_rate >= 32'(VCO_MIN) * ref_v) && (fb_rate <= 32'(VCO_MAX) * ref_v);
        out_ok  = (fb_rate >= 32'(OUT_MIN) * prod) && (fb_rate <= 32'(OUT_MAX) * prod);
        ok      = idx_ok && nz_ok && fb_ok && vco_ok && out_ok;
    end
endmodule

// File: rtl/pll_poll_timer.sv
`timescale 1ns/1ps
// Module: pll_poll_timer
// Spaces lock samples by POLL_CYCLES idle cycles and counts unlocked samples
// so the sequencer can give up after MAX_POLLS of them. Assumes
// POLL_CYCLES >= 1 and MAX_POLLS >= 1.
module pll_poll_timer #(
    parameter int POLL_CYCLES = 125,
    parameter int MAX_POLLS   = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic gap_load,
    output logic gap_done,
    output logic last_poll
);
    localparam int GW = $clog2(POLL_CYCLES + 1);
    localparam int PW = $clog2(MAX_POLLS + 1);

    logic [GW-1:0] gap_cnt;
    logic [PW-1:0] poll_cnt;

    // Interval down-counter, reloaded after every unlocked sample
    always_ff @(posedge clk) begin
        if (!rst_n)               gap_cnt <= '0;
        else if (gap_load)        gap_cnt <= GW'(POLL_CYCLES);
        else if (gap_cnt != '0)   gap_cnt <= gap_cnt - 1'b1;
    end

    // Unlocked-sample counter, cleared at the start of each request
    always_ff @(posedge clk) begin
        if (!rst_n || clr)        poll_cnt <= '0;
        else if (gap_load)        poll_cnt <= poll_cnt + 1'b1;
    end

    assign gap_done  = (gap_cnt == GW'(1));
    assign last_poll = (poll_cnt == PW'(MAX_POLLS - 1));

    // R7: the interval counter never holds more than one interval
    p_gap_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gap_cnt <= GW'(POLL_CYCLES));
    // R8: the sequencer stops before the sample count passes its limit
    p_poll_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt <= PW'(MAX_POLLS - 1));
endmodule

// File: rtl/pll_seq_ctrl.sv
`timescale 1ns/1ps
// Module: pll_seq_ctrl
// Main sequencer. It latches a request, consults the range checker and then
// walks five read-modify-write steps, with a lock-sample loop between the
// divider writes and the normal-mode write. Assumes read data is valid the
// cycle after reg_rd.
module pll_seq_ctrl
    import pll_seq_pkg::*;
#(
    parameter logic [AW-1:0] MODE_ADDR = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [REF_W-1:0] req_ref,
    input  logic [FB_W-1:0]  req_fb,
    input  logic [PD_W-1:0]  req_pd1,
    input  logic [PD_W-1:0]  req_pd2,
    input  logic             range_ok,
    input  logic             gap_done,
    input  logic             last_poll,
    output logic [IDX_W-1:0] lat_idx,
    output logic [REF_W-1:0] lat_ref,
    output logic [FB_W-1:0]  lat_fb,
    output logic [PD_W-1:0]  lat_pd1,
    output logic [PD_W-1:0]  lat_pd2,
    output logic             tmr_clr,
    output logic             gap_load,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [AW-1:0]    reg_addr,
    output logic             reg_rd,
    output logic             reg_wr,
    output logic [DW-1:0]    reg_wdata,
    input  logic [DW-1:0]    reg_rdata
);
    seq_state_t    state;
    seq_step_t     step;
    logic [DW-1:0] mod_data;
    logic [DW-1:0] mode_mask;
    logic [DW-1:0] modified;
    logic          lock_seen;

    assign mode_mask = DW'(1) << mode_pos(lat_idx);
    assign lock_seen = reg_rdata[LOCK_BIT];

    // New register value for the current step, built from the read data
    always_comb begin
        modified = reg_rdata;
        case (step)
            STEP_SLOW: modified = reg_rdata & ~mode_mask;
            STEP_INT:  modified[INT_BIT] = 1'b1;
            STEP_DIV0: begin
                modified[FB_LSB +: FB_W]  = lat_fb;
                modified[PD1_LSB +: PD_W] = lat_pd1;
            end
            STEP_DIV1: begin
                modified[REF_LSB +: REF_W] = lat_ref;
                modified[PD2_LSB +: PD_W]  = lat_pd2;
            end
            default:   modified = reg_rdata | mode_mask;
        endcase
    end

    // Request latch; only an idle sequencer accepts a new request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_idx <= '0; lat_ref <= '0; lat_fb <= '0; lat_pd1 <= '0; lat_pd2 <= '0;
        end else if (state == ST_IDLE && start) begin
            lat_idx <= req_idx; lat_ref <= req_ref; lat_fb <= req_fb;
            lat_pd1 <= req_pd1; lat_pd2 <= req_pd2;
        end
    end

    // State and step sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step     <= STEP_SLOW;
            mod_data <= '0;
        end else begin
            case (state)
                ST_IDLE:  if (start) state <= ST_CHECK;
                ST_CHECK: begin
                    step  <= STEP_SLOW;
                    state <= range_ok ? ST_RD : ST_FAIL;
                end
                ST_RD:    state <= ST_CAP;
                ST_CAP: begin
                    mod_data <= modified;
                    state    <= ST_WR;
                end
                ST_WR: begin
                    case (step)
                        STEP_SLOW: begin step <= STEP_INT;  state <= ST_RD; end
                        STEP_INT:  begin step <= STEP_DIV0; state <= ST_RD; end
                        STEP_DIV0: begin step <= STEP_DIV1; state <= ST_RD; end
                        STEP_DIV1: state <= ST_POLL;
                        default:   state <= ST_DONE;
                    endcase
                end
                ST_POLL:  state <= ST_PCAP;
                ST_PCAP: begin
                    if (lock_seen) begin
                        step  <= STEP_NORM;
                        state <= ST_RD;
                    end else if (last_poll) begin
                        state <= ST_FAIL;
                    end else begin
                        state <= ST_GAP;
                    end
                end
                ST_GAP:   if (gap_done) state <= ST_POLL;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Register-port and handshake decode
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE) || (state == ST_FAIL);
        err       = (state == ST_FAIL);
        reg_rd    = (state == ST_RD) || (state == ST_POLL);
        reg_wr    = (state == ST_WR);
        reg_wdata = mod_data;
        tmr_clr   = (state == ST_CHECK);
        gap_load  = (state == ST_PCAP) && !lock_seen && !last_poll;
        if (step == STEP_SLOW || step == STEP_NORM) reg_addr = MODE_ADDR;
        else reg_addr = {lat_idx, (step != STEP_DIV0)};
    end

    // R11: one access per cycle on the register port
    p_rw_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));
    // R9: completion is a single-cycle pulse that ends the busy window
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    // R1: a checker rejection is never followed by a write
    p_reject_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && !range_ok) |=> !reg_wr);
    // R7: the normal-mode step is entered only right after a locked sample
    p_lock_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_NORM && !$stable(step)) |-> $past(reg_rdata[LOCK_BIT]));
    // R10: a start while busy leaves the latched request alone
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(lat_idx));
endmodule

// File: rtl/pll_reprog_seq.sv
`timescale 1ns/1ps
// Module: pll_reprog_seq (top)
// Reprograms one of five integer-mode PLLs through a register-bank port:
// range check, slow mode, integer mode, divider writes, lock sampling,
// normal mode. Assumes a bank with one-cycle read latency.
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int              POLL_CYCLES = 125,
    parameter int              MAX_POLLS   = 1000,
    parameter logic [AW-1:0]   MODE_ADDR   = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [REF_W-1:0] req_ref,
    input  logic [FB_W-1:0]  req_fb,
    input  logic [PD_W-1:0]  req_pd1,
    input  logic [PD_W-1:0]  req_pd2,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [AW-1:0]    reg_addr,
    output logic             reg_rd,
    output logic             reg_wr,
    output logic [DW-1:0]    reg_wdata,
    input  logic [DW-1:0]    reg_rdata
);
    logic [IDX_W-1:0] lat_idx;
    logic [REF_W-1:0] lat_ref;
    logic [FB_W-1:0]  lat_fb;
    logic [PD_W-1:0]  lat_pd1, lat_pd2;
    logic             range_ok, tmr_clr, gap_load, gap_done, last_poll;

    pll_range_check u_range (
        .idx(lat_idx), .refdiv(lat_ref), .fbdiv(lat_fb),
        .pd1(lat_pd1), .pd2(lat_pd2), .ok(range_ok)
    );

    pll_poll_timer #(.POLL_CYCLES(POLL_CYCLES), .MAX_POLLS(MAX_POLLS)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .gap_load(gap_load),
        .gap_done(gap_done), .last_poll(last_poll)
    );

    pll_seq_ctrl #(.MODE_ADDR(MODE_ADDR)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_idx(req_idx), .req_ref(req_ref), .req_fb(req_fb),
        .req_pd1(req_pd1), .req_pd2(req_pd2),
        .range_ok(range_ok), .gap_done(gap_done), .last_poll(last_poll),
        .lat_idx(lat_idx), .lat_ref(lat_ref), .lat_fb(lat_fb),
        .lat_pd1(lat_pd1), .lat_pd2(lat_pd2),
        .tmr_clr(tmr_clr), .gap_load(gap_load),
        .busy(busy), .done(done), .err(err),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );
endmodule

// File: tb/pll_reprog_seq_tb.sv
`timescale 1ns/1ps
module pll_reprog_seq_tb;
    localparam int POLL = 6;
    localparam int MAXP = 12;
    localparam logic [3:0] MADDR = 4'hF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  req_idx = '0;
    logic [5:0]  req_ref = '0;
    logic [11:0] req_fb = '0;
    logic [2:0]  req_pd1 = '0, req_pd2 = '0;
    logic        busy, done, err, reg_rd, reg_wr;
    logic [3:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;

    always #4 clk = ~clk;

    pll_reprog_seq #(.POLL_CYCLES(POLL), .MAX_POLLS(MAXP), .MODE_ADDR(MADDR)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_idx(req_idx), .req_ref(req_ref),
        .req_fb(req_fb), .req_pd1(req_pd1), .req_pd2(req_pd2), .busy(busy), .done(done),
        .err(err), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // ---------------- register bank and lock model ----------------
    logic [15:0] mode_m;
    logic [15:0] con0_m [5];
    logic [15:0] con1_m [5];
    int          lock_cnt [5];
    int          cur_idx = 0;
    bit          lock_allow = 1'b1;
    int          lock_delay = 0;
    int          cyc = 0, wtot = 0, rtot = 0, dtot = 0;
    logic [3:0]  wlog_a [256];
    logic [15:0] wlog_d [256];
    bit          wlog_l [256];
    int          rlog [256];
    int          n_total = 0, n_bad = 0;

    function automatic bit is_locked(input int i);
        return lock_allow && (lock_cnt[i] == 0);
    endfunction

    function automatic logic [15:0] bank_read(input logic [3:0] a);
        int i;
        i = int'(a) / 2;
        if (a == MADDR) return mode_m;
        if (a < 4'd10) begin
            if (a[0]) return con1_m[i] | (is_locked(i) ? 16'h0400 : 16'h0000);
            return con0_m[i];
        end
        return 16'h0000;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            mode_m    <= 16'hB3D5;
            reg_rdata <= '0;
            for (int i = 0; i < 5; i++) begin
                con0_m[i]   <= 16'h8A5C ^ 16'(i * 16'h0111);
                con1_m[i]   <= (16'hE9B7 ^ 16'(i << 13)) & ~16'h0400;
                lock_cnt[i] <= 0;
            end
        end else begin
            for (int i = 0; i < 5; i++)
                if (lock_cnt[i] != 0) lock_cnt[i] <= lock_cnt[i] - 1;
            if (reg_wr) begin
                wlog_a[wtot[7:0]] <= reg_addr;
                wlog_d[wtot[7:0]] <= reg_wdata;
                wlog_l[wtot[7:0]] <= (cur_idx < 5) ? is_locked(cur_idx) : 1'b0;
                wtot <= wtot + 1;
                if (reg_addr == MADDR) mode_m <= reg_wdata;
                else if (reg_addr < 4'd10) begin
                    if (reg_addr[0]) con1_m[int'(reg_addr) / 2] <= reg_wdata & ~16'h0400;
                    else             con0_m[int'(reg_addr) / 2] <= reg_wdata;
                    lock_cnt[int'(reg_addr) / 2] <= lock_delay;
                end
            end
            if (reg_rd) begin
                reg_rdata <= bank_read(reg_addr);
                if (int'(reg_addr) == cur_idx * 2 + 1) begin
                    rlog[rtot[7:0]] <= cyc;
                    rtot <= rtot + 1;
                end
            end
            if (done) dtot <= dtot + 1;
        end
    end

    // ---------------- reference calculations ----------------
    function automatic bit exp_ok(input int idx, r, f, p1, p2);
        longint vco, outk;
        if (idx > 4 || r == 0 || p1 == 0 || p2 == 0) return 1'b0;
        if (f < 16 || f > 3200) return 1'b0;
        vco = 64'(24000) * f / r;
        if (vco < 800000 || vco > 3200000) return 1'b0;
        outk = vco / p1 / p2;
        if (outk < 16000 || outk > 3200000) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int bitpos(input int idx);
        case (idx)
            0: return 0;
            1: return 1;
            2: return 4;
            3: return 8;
            default: return 12;
        endcase
    endfunction

    task automatic chk(input bit cond, input string tag, input longint act, input longint exp);
        n_total++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // ---------------- one request ----------------
    task automatic run_op(input int idx, r, f, p1, p2, input bit allow, input int delay,
                          input bit extra);
        bit ok;
        int k, pos, oth, w_s, r_s, d_s, nw, nr;
        logic [15:0] pre_m, pre0, pre1, oth0, oth1, m, e1, e3;
        bit gaps_ok, got_err;
        cur_idx = idx; lock_allow = allow; lock_delay = delay;
        ok  = exp_ok(idx, r, f, p1, p2);
        pos = bitpos(idx);
        oth = (idx + 1) % 5;
        pre_m = mode_m;
        pre0 = (idx < 5) ? con0_m[idx] : 16'h0;
        pre1 = (idx < 5) ? con1_m[idx] : 16'h0;
        oth0 = con0_m[oth]; oth1 = con1_m[oth];
        w_s = wtot; r_s = rtot; d_s = dtot;
        @(negedge clk);
        start = 1'b1; req_idx = 3'(idx); req_ref = 6'(r); req_fb = 12'(f);
        req_pd1 = 3'(p1); req_pd2 = 3'(p2);
        @(negedge clk);
        start = 1'b0; k = 1;
        chk(busy === 1'b1, "R9 busy after start", busy, 1);
        while (!done && k < 3000) begin
            if (extra && k == 3) begin
                start = 1'b1; req_idx = 3'(oth); req_ref = 6'd1; req_fb = 12'd40;
                req_pd1 = 3'd1; req_pd2 = 3'd1;
            end else start = 1'b0;
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        got_err = err;
        nw = wtot - w_s;
        nr = rtot - r_s;
        if (!ok) begin
            chk(got_err == 1'b1, "R1 reject err", got_err, 1);
            chk(k == 2, "R1 reject latency", k, 2);
            chk(nw == 0, "R1 no writes on reject", nw, 0);
        end else if (!allow) begin
            chk(got_err == 1'b1, "R8 timeout err", got_err, 1);
            chk(nw == 4, "R8 writes before timeout", nw, 4);
            chk(mode_m[pos] == 1'b0, "R8 left in slow mode", mode_m, pre_m & ~(16'h1 << pos));
            chk(nr - 2 == MAXP, "R8 sample count", nr - 2, MAXP);
        end else begin
            chk(got_err == 1'b0, "R2 accepted no err", got_err, 0);
            chk(nw == 5, "R2 write count", nw, 5);
            m  = wlog_d[8'(w_s)];
            chk(wlog_a[8'(w_s)] == MADDR && m == (pre_m & ~(16'h1 << pos)),
                "R3 slow-mode write", m, pre_m & ~(16'h1 << pos));
            e1 = (pre1 | 16'h1000) & ~16'h0400;
            m  = wlog_d[8'(w_s + 1)];
            chk(int'(wlog_a[8'(w_s + 1)]) == idx * 2 + 1 && (m & ~16'h0400) == e1,
                "R4 integer-mode write", m, e1);
            m  = wlog_d[8'(w_s + 2)];
            chk(int'(wlog_a[8'(w_s + 2)]) == idx * 2 &&
                m == ((pre0 & 16'h8000) | 16'(p1 << 12) | 16'(f)), "R5 control word 0",
                m, (pre0 & 16'h8000) | 16'(p1 << 12) | 16'(f));
            e3 = (e1 & 16'hFA00) | 16'(p2 << 6) | 16'(r);
            m  = wlog_d[8'(w_s + 3)];
            chk(int'(wlog_a[8'(w_s + 3)]) == idx * 2 + 1 && (m & ~16'h0400) == e3,
                "R6 control word 1", m, e3);
            m  = wlog_d[8'(w_s + 4)];
            chk(wlog_a[8'(w_s + 4)] == MADDR && m == (pre_m | (16'h1 << pos)),
                "R3 normal-mode write", m, pre_m | (16'h1 << pos));
            chk(wlog_l[8'(w_s + 4)] == 1'b1, "R7 lock before normal", wlog_l[8'(w_s + 4)], 1);
            gaps_ok = 1'b1;
            for (int j = r_s + 3; j < rtot; j++)
                if (rlog[8'(j)] - rlog[8'(j - 1)] != POLL + 2) gaps_ok = 1'b0;
            chk(gaps_ok, "R7 sample spacing", gaps_ok, 1);
        end
        @(negedge clk);
        chk(!busy && !done && !err, "R9 idle after done", {busy, done, err}, 0);
        if (extra) begin
            repeat (6) @(negedge clk);
            chk(dtot - d_s == 1, "R10 single done", dtot - d_s, 1);
            chk(con0_m[oth] == oth0 && con1_m[oth] == oth1, "R10 other PLL untouched",
                con0_m[oth], oth0);
        end
        lock_allow = 1'b1;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        bit rw_clash;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !reg_rd && !reg_wr, "R9 reset state",
            {busy, done, err, reg_rd, reg_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(5, 1, 40, 1, 1, 1, 0, 0);          // R1 bad index
        run_op(0, 1, 15, 1, 1, 1, 0, 0);          // R1 multiplier below 16
        run_op(0, 1, 34, 1, 1, 1, 3, 0);          // R1 lowest legal VCO point
        run_op(1, 1, 33, 1, 1, 1, 0, 0);          // R1 VCO just under 800
        run_op(2, 1, 133, 2, 1, 1, 20, 0);        // R1 VCO just under 3200
        run_op(2, 1, 134, 2, 1, 1, 0, 0);         // R1 VCO just over 3200
        run_op(3, 63, 3200, 1, 1, 1, 9, 0);       // R1 multiplier at 3200
        run_op(3, 63, 3201, 1, 1, 1, 0, 0);       // R1 multiplier over 3200
        run_op(4, 0, 100, 1, 1, 1, 0, 0);         // R1 zero reference divider
        run_op(4, 2, 100, 0, 1, 1, 0, 0);         // R1 zero post divider
        run_op(4, 2, 100, 3, 1, 1, 0, 0);         // R2 immediate lock
        run_op(1, 1, 50, 2, 2, 0, 0, 0);          // R8 no lock
        run_op(2, 1, 60, 1, 1, 1, 25, 1);         // R10 start while busy
        for (int n = 0; n < 40; n++) begin
            int idx, r, f, p1, p2;
            idx = int'($urandom % 6);
            r   = ($urandom % 16 == 0) ? 0 : 1 + int'($urandom % 3);
            f   = 20 + int'($urandom % 300);
            p1  = int'($urandom % 8);
            p2  = int'($urandom % 8);
            run_op(idx, r, f, p1, p2, 1, int'($urandom % 40), 0);
        end
        rw_clash = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (reg_rd && reg_wr) rw_clash = 1'b1;
        end
        chk(!rw_clash, "R11 port idle and exclusive", rw_clash, 0);
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", n_total + 1, n_bad + 1);
        $finish;
    end
endmodule